// File: doc/BRIEF.md
# RTC Alarm and Periodic Interrupt Flag Controller

This block holds the three interrupt flags of a real-time clock and drives its two active-low interrupt pins. Two alarm channels, weekly and daily, each take a one-cycle match pulse from an external time comparator. The flag is raised only after a fixed number of 32.768 kHz ticks, and only while that channel's alarm enable is 1. A third channel, the periodic interrupt, sets its flag as soon as a periodic-event pulse arrives.

Software can only clear a flag, by writing 0 to its bit on a simple write strobe. Writing 1 does nothing. After a clear, the flag and its pin stay released until the next event on that channel. A disabled alarm channel reads 0. Dropping its enable also cancels any delayed set that is still pending.

The weekly flag drives pin B. Pin A is low while either the daily flag or the periodic flag is set.

Top module: `rtc_irq_flags`

## Requirements
- R1: After an enabled alarm match pulse, the alarm flag becomes 1 on the clock edge of the DLY_TICKS-th tick (default 2) that follows the match cycle. A tick in the same cycle as the match is not counted, and a new match restarts the count.
- R2: A match pulse that arrives while the channel's enable is 0 is ignored, and no flag follows it.
- R3: On a write, a wr_data bit of 1 leaves the corresponding flag unchanged. Bit 2 is weekly, bit 1 is daily, bit 0 is periodic.
- R4: On a write, a wr_data bit of 0 clears the corresponding flag on the next edge, using the same bit positions as R3. The flag then stays 0 until that channel's next set event.
- R5: irq_b_n is low exactly when the weekly flag reads 1. irq_a_n is low exactly when the daily or the periodic flag reads 1.
- R6: While an alarm enable is 0, that flag reads 0 in the same cycle. Dropping the enable clears the stored flag and cancels any pending delayed set.
- R7: A periodic-event pulse sets the periodic flag on the next edge.
- R8: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R9: Under reset, all flags read 0 and both pins are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable at 32.768 kHz |
| wk_match | input | 1 | Weekly alarm match pulse |
| dy_match | input | 1 | Daily alarm match pulse |
| wk_en | input | 1 | Weekly alarm enable |
| dy_en | input | 1 | Daily alarm enable |
| per_evt | input | 1 | Periodic interrupt event pulse |
| wr_en | input | 1 | Flag write strobe |
| wr_data | input | 3 | Write data, where a 0 clears (bit 2 weekly, bit 1 daily, bit 0 periodic) |
| rd_flags | output | 3 | Readable flags, same bit positions as wr_data |
| irq_a_n | output | 1 | Active-low interrupt pin for daily alarm or periodic flag |
| irq_b_n | output | 1 | Active-low interrupt pin for weekly alarm flag |

## Verification
The alarm path is driven with ticks spaced apart, with a tick that lands in the match cycle, and with matches that come while the channel is disabled. These show whether the delay counts the right edges and whether the enable gates the capture of a match.

Writes are applied with all ones and with a single zero in each bit position. This separates the clear-only rule and the bit mapping from any accidental effect on the other flags.

Set events that coincide with a clearing write check the set-wins rule. Dropping the enable in the middle of a pending delay, and again after the flag is set, checks both the cancellation and the immediate read-as-zero behaviour.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int FLG_PER = 0;
    localparam int FLG_DAY = 1;
    localparam int FLG_WK  = 2;
    localparam int NUM_FLG = 3;
    localparam int NUM_ALM = 2;
    typedef logic [NUM_FLG-1:0] flg_vec_t;
endpackage

// File: rtl/rtc_alarm_ch.sv
module rtc_alarm_ch #(
    parameter int DLY_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic en,
    input  logic clr,
    output logic flag
);
    localparam int CNT_W = (DLY_TICKS < 2) ? 1 : $clog2(DLY_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DLY_TICKS - 1);

    typedef struct packed {
        logic             pend;
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } st_t;

    st_t st_d, st_q;
    logic fire;

    always_comb begin
        st_d = st_q;
        fire = st_q.pend && tick && (st_q.cnt == LAST);
        if (!en) begin
            st_d = '0;
        end else begin
            if (clr) begin
                st_d.flag = 1'b0;
            end
            if (match) begin
                st_d.pend = 1'b1;
                st_d.cnt  = '0;
            end else if (st_q.pend && tick) begin
                if (fire) begin
                    st_d.pend = 1'b0;
                    st_d.flag = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag & en;

    AST_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(tick));                               // R1
    AST_PEND_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(en && match));                        // R2
    AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.flag && !clr) |=> st_q.flag);                        // R3
    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !st_q.pend) |=> !st_q.flag);                             // R4
    AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!st_q.flag && !st_q.pend));                             // R6
endmodule

// File: rtl/rtc_per_ch.sv
module rtc_per_ch (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.flag = 1'b0;
        if (evt) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    AST_PER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> st_q.flag);                                              // R7
    AST_PER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !st_q.flag);                                   // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt) |=> st_q.flag);                                     // R8
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
#(
    parameter int DLY_TICKS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wk_match,
    input  logic                dy_match,
    input  logic                wk_en,
    input  logic                dy_en,
    input  logic                per_evt,
    input  logic                wr_en,
    input  logic [NUM_FLG-1:0]  wr_data,
    output logic [NUM_FLG-1:0]  rd_flags,
    output logic                irq_a_n,
    output logic                irq_b_n
);
    // alarm slot 0 = daily, slot 1 = weekly
    logic [NUM_ALM-1:0] alm_match, alm_en, alm_clr, alm_flag;
    logic               per_clr, per_flag;

    assign alm_match = {wk_match, dy_match};
    assign alm_en    = {wk_en, dy_en};
    assign alm_clr   = {wr_en & ~wr_data[FLG_WK], wr_en & ~wr_data[FLG_DAY]};
    assign per_clr   = wr_en & ~wr_data[FLG_PER];

    for (genvar i = 0; i < NUM_ALM; i++) begin : g_alm
        rtc_alarm_ch #(.DLY_TICKS(DLY_TICKS)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .match (alm_match[i]),
            .en    (alm_en[i]),
            .clr   (alm_clr[i]),
            .flag  (alm_flag[i])
        );
    end

    rtc_per_ch u_per (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (per_evt),
        .clr   (per_clr),
        .flag  (per_flag)
    );

    always_comb begin
        rd_flags          = '0;
        rd_flags[FLG_PER] = per_flag;
        rd_flags[FLG_DAY] = alm_flag[0];
        rd_flags[FLG_WK]  = alm_flag[1];
    end

    assign irq_b_n = ~alm_flag[1];
    assign irq_a_n = ~(alm_flag[0] | per_flag);

    AST_RST_PINS_HIGH: assert property (@(posedge clk)
        !rst_n |-> (irq_a_n && irq_b_n));                                // R9
endmodule

// File: tb/rtc_irq_flags_bench.sv
module rtc_irq_flags_bench;
    localparam int CLK_P = 10;
    localparam int NVEC  = 35;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick, wk_match, dy_match, wk_en, dy_en, per_evt, wr_en;
    logic [2:0] wr_data;
    logic [2:0] rd_flags;
    logic       irq_a_n, irq_b_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    rtc_irq_flags u_rtc_irq_flags (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wk_match(wk_match),
        .dy_match(dy_match), .wk_en(wk_en), .dy_en(dy_en), .per_evt(per_evt),
        .wr_en(wr_en), .wr_data(wr_data), .rd_flags(rd_flags),
        .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
    );

    // fields: req[18:15] wr[14] data[13:11] wkm dym wke dye per tick [10:5]
    //         exp_rd[4:2] exp_a[1] exp_b[0]
    localparam logic [18:0] VEC [NVEC] = '{
        19'b0101_0_000_001100_000_11,  // 0  R5 idle
        19'b0001_0_000_101100_000_11,  // 1  R1 weekly match
        19'b0001_0_000_001101_000_11,  // 2  R1 first tick
        19'b0001_0_000_001100_000_11,  // 3  R1 gap
        19'b0001_0_000_001101_100_10,  // 4  R1 second tick sets, R5 pin B
        19'b0011_1_111_001100_100_10,  // 5  R3 write ones
        19'b0100_1_011_001100_000_11,  // 6  R4 clear weekly
        19'b0001_0_000_011100_000_11,  // 7  R1 daily match
        19'b0001_0_000_001101_000_11,  // 8
        19'b0101_0_000_001101_010_01,  // 9  R5 daily drives A
        19'b0111_0_000_001110_011_01,  // 10 R7 periodic set
        19'b0100_1_110_001100_010_01,  // 11 R4 clear periodic only
        19'b0100_1_101_001100_000_11,  // 12 R4 clear daily
        19'b1000_1_110_001110_001_01,  // 13 R8 set beats clear
        19'b0100_1_110_001100_000_11,  // 14 R4
        19'b0110_0_000_011100_000_11,  // 15 R6 daily match
        19'b0110_0_000_001001_000_11,  // 16 R6 disable cancels
        19'b0110_0_000_001101_000_11,  // 17 R6
        19'b0110_0_000_001101_000_11,  // 18 R6 nothing pending
        19'b0001_0_000_101100_000_11,  // 19
        19'b0001_0_000_001101_000_11,  // 20
        19'b0001_0_000_001101_100_10,  // 21 R1
        19'b0110_0_000_000100_000_11,  // 22 R6 reads 0 at once
        19'b0110_0_000_001100_000_11,  // 23 R6 stored flag gone
        19'b0010_0_000_100100_000_11,  // 24 R2 match while disabled
        19'b0010_0_000_001101_000_11,  // 25 R2
        19'b0010_0_000_001101_000_11,  // 26 R2
        19'b0001_0_000_011100_000_11,  // 27
        19'b0001_0_000_001101_000_11,  // 28
        19'b1000_1_101_001101_010_01,  // 29 R8 alarm set beats clear
        19'b0100_1_101_001100_000_11,  // 30 R4
        19'b0001_0_000_011101_000_11,  // 31 R1 tick with match not counted
        19'b0001_0_000_001101_000_11,  // 32 R1
        19'b0001_0_000_001101_010_01,  // 33 R1
        19'b0100_1_101_001100_000_11   // 34 R4
    };

    task automatic check(input string req, input string what,
                         input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got rd=%b a=%b b=%b expected rd=%b a=%b b=%b",
                     req, what, act[4:2], act[1], act[0], exp[4:2], exp[1], exp[0]);
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {tick, wk_match, dy_match, wk_en, dy_en, per_evt, wr_en} = '0;
        wr_data = '0;
        repeat (3) @(posedge clk);
        #1 check("R9", "reset", {rd_flags, irq_a_n, irq_b_n}, 5'b000_11);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            wr_en    = VEC[i][14];
            wr_data  = VEC[i][13:11];
            wk_match = VEC[i][10];
            dy_match = VEC[i][9];
            wk_en    = VEC[i][8];
            dy_en    = VEC[i][7];
            per_evt  = VEC[i][6];
            tick     = VEC[i][5];
            @(posedge clk);
            #1 check($sformatf("R%0d", VEC[i][18:15]), $sformatf("row %0d", i),
                     {rd_flags, irq_a_n, irq_b_n}, VEC[i][4:0]);
        end

        // directed: R7 periodic set then R9 reset clears it
        @(negedge clk);
        {tick, wk_match, dy_match, wr_en} = '0;
        per_evt = 1'b1;
        @(posedge clk);
        #1 check("R7", "periodic pulse", {rd_flags, irq_a_n, irq_b_n}, 5'b001_01);
        @(negedge clk);
        per_evt = 1'b0;
        rst_n   = 1'b0;
        #1 check("R9", "reset mid-run", {rd_flags, irq_a_n, irq_b_n}, 5'b000_11);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 check("R9", "after release", {rd_flags, irq_a_n, irq_b_n}, 5'b000_11);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule